// File: doc/BRIEF.md
# Configuration-Space Serial EEPROM Port

This block lets host software drive a three-wire serial EEPROM by writing to two
vendor-specific configuration offsets, and read the EEPROM's data line back
through bit 0 position of the configuration byte at offset zero. A write to the
clocking offset selects the chip and sets the clock and data-in pins from two
bits of the written byte. A write to the release offset drops the chip select
and parks the other two pins low. A byte read at offset zero is forced to zero
whenever the EEPROM data-out line is low. Every other configuration write is
passed unchanged to the default configuration handler.

After reset, an init engine streams a 128-byte default image to a byte RAM port,
one byte per accepted transfer, in ascending address order. The last two bytes
carry a 16-bit checksum picked so that the image's little-endian word sum equals
0x1234. The RAM port is valid/ready: while `img_valid` is high and `img_ready`
is low, address and data hold still and the engine waits. Configuration writes
are back-pressured (`cfg_wr_ready` low) until the image is complete. A write is
taken in a cycle where `cfg_wr_valid` and `cfg_wr_ready` are both high.

Top module: `seep_cfg_port`

## Requirements
- R1: During and right after reset, `ee_cs`, `ee_sk`, `ee_di`, `pass_wr_valid` and `init_done` are low.
- R2: An accepted write to offset 0x80 sets `ee_cs` high, `ee_sk` to data bit 7 and `ee_di` to data bit 6, visible the cycle after acceptance.
- R3: An accepted write to offset 0xC0 drives `ee_cs`, `ee_sk` and `ee_di` low the cycle after acceptance, whatever the data.
- R4: An accepted write to any offset other than 0x80 and 0xC0 appears on `pass_wr_*` for exactly one cycle, the cycle after acceptance, with offset and data unchanged, and leaves the EEPROM pins unchanged; writes to 0x80 and 0xC0 are not forwarded.
- R5: `cfg_rd_data` equals zero when `cfg_rd_off` is 0, `cfg_rd_single` is high and `ee_do` is low; in every other case it equals `cfg_rd_raw` (combinational).
- R6: The init engine offers addresses 0 to 127 in ascending order, one per accepted transfer, holding address and data stable while `img_ready` is low; `init_done` is high in the cycle after the transfer of address 127 and stays high.
- R7: Image bytes at even addresses 0 to 30 are 0x57, at odd addresses 1 to 31 are 0x00; byte 64 is 0x07, byte 65 is 0x0F, byte 67 is 0x04, byte 68 is 0x07; every other byte below 126 is 0x00.
- R8: Byte 126 is the low byte and byte 127 the high byte of 0x1234 minus the modulo-2^16 sum of the little-endian words formed by byte pairs (0,1) to (124,125).
- R9: `cfg_wr_ready` is low until `init_done` is high; a write offered earlier has no effect on the pins or the forward port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Configuration write offered |
| cfg_wr_ready | output | 1 | Configuration write can be taken |
| cfg_wr_off | input | 8 | Configuration write offset |
| cfg_wr_data | input | 8 | Configuration write byte |
| pass_wr_valid | output | 1 | Forwarded write strobe to default handler |
| pass_wr_off | output | 8 | Forwarded write offset |
| pass_wr_data | output | 8 | Forwarded write byte |
| cfg_rd_off | input | 8 | Configuration read offset |
| cfg_rd_single | input | 1 | Read is one byte wide |
| cfg_rd_raw | input | 8 | Byte from the default configuration space |
| cfg_rd_data | output | 8 | Byte returned to the host |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in |
| ee_do | input | 1 | EEPROM serial data out |
| img_valid | output | 1 | Image byte offered |
| img_ready | input | 1 | RAM takes the offered byte |
| img_addr | output | 7 | Image byte address |
| img_wdata | output | 8 | Image byte value |
| init_done | output | 1 | Image fully written |

## Verification
Pin and forward-port results are registered and due one cycle after the accepting edge, so the bench drives a write at a falling edge and samples at the next falling edge. The read mask is combinational and is sampled a fraction of a cycle after its inputs change, over every offset, both widths and both data-out levels. Image bytes are captured just before the edge that accepts them, with `img_ready` throttled in a fixed pattern, and the whole image is compared with bytes and checksum computed in the bench; `init_done` is sampled at the falling edge after the final accepted transfer.

// File: rtl/seep_pkg.sv
package seep_pkg;

  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_RUN  = 2'd1,
    INIT_DONE = 2'd2
  } init_state_e;

  // Default byte of the adapter image at a given address.
  function automatic logic [7:0] seep_default(input int unsigned a);
    logic [7:0] v;
    v = 8'h00;
    if (a < 32) begin
      v = (a % 2 == 0) ? 8'h57 : 8'h00;
    end else begin
      case (a)
        64:      v = 8'h07;
        65:      v = 8'h0F;
        67:      v = 8'h04;
        68:      v = 8'h07;
        default: v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/seep_img_init.sv
module seep_img_init
  import seep_pkg::*;
#(
  parameter int          IMG_BYTES = 128,
  parameter logic [15:0] CSUM_SEED = 16'h1234,
  localparam int         AW        = $clog2(IMG_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          img_valid,
  input  logic          img_ready,
  output logic [AW-1:0] img_addr,
  output logic [7:0]    img_wdata,
  output logic          done
);

  localparam int LO_IDX = IMG_BYTES - 2;
  localparam int HI_IDX = IMG_BYTES - 1;

  init_state_e   state;
  logic [AW-1:0] idx;
  logic [15:0]   wsum;
  logic [7:0]    dflt;
  logic [15:0]   csum;

  always_comb begin
    dflt = seep_default(int'(idx));
    csum = CSUM_SEED - wsum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= INIT_IDLE;
      idx   <= '0;
      wsum  <= '0;
    end else begin
      case (state)
        INIT_IDLE: state <= INIT_RUN;
        INIT_RUN: begin
          if (img_ready) begin
            if (int'(idx) < LO_IDX) begin
              wsum <= idx[0] ? wsum + {dflt, 8'h00} : wsum + {8'h00, dflt};
            end
            if (int'(idx) == HI_IDX) state <= INIT_DONE;
            else                     idx   <= idx + 1'b1;
          end
        end
        default: state <= INIT_DONE;
      endcase
    end
  end

  always_comb begin
    img_valid = (state == INIT_RUN);
    img_addr  = idx;
    done      = (state == INIT_DONE);
    if (int'(idx) == LO_IDX)      img_wdata = csum[7:0];
    else if (int'(idx) == HI_IDX) img_wdata = csum[15:8];
    else                          img_wdata = dflt;
  end

  // R6
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && !img_ready) |=> (img_valid && $stable(img_addr) && $stable(img_wdata)));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (img_valid && img_ready && int'(img_addr) != HI_IDX) |=> (img_valid && img_addr == $past(img_addr) + 1'b1));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !img_valid));

endmodule

// File: rtl/seep_pin_ctl.sv
module seep_pin_ctl #(
  parameter int             OFF_W    = 8,
  parameter int             DATA_W   = 8,
  parameter logic [OFF_W-1:0] OFF_CLK  = 8'h80,
  parameter logic [OFF_W-1:0] OFF_REL  = 8'hC0,
  parameter int             SK_BIT   = 7,
  parameter int             DI_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pass_valid,
  output logic [OFF_W-1:0]  pass_off,
  output logic [DATA_W-1:0] pass_data,
  output logic              cs,
  output logic              sk,
  output logic              di
);

  logic hit_clk, hit_rel;

  always_comb begin
    hit_clk = (wr_off == OFF_CLK);
    hit_rel = (wr_off == OFF_REL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs         <= 1'b0;
      sk         <= 1'b0;
      di         <= 1'b0;
      pass_valid <= 1'b0;
      pass_off   <= '0;
      pass_data  <= '0;
    end else begin
      pass_valid <= 1'b0;
      if (wr_fire) begin
        if (hit_clk) begin
          cs <= 1'b1;
          sk <= wr_data[SK_BIT];
          di <= wr_data[DI_BIT];
        end else if (hit_rel) begin
          cs <= 1'b0;
          sk <= 1'b0;
          di <= 1'b0;
        end else begin
          pass_valid <= 1'b1;
          pass_off   <= wr_off;
          pass_data  <= wr_data;
        end
      end
    end
  end

  // R3
  idle_pins_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!sk && !di));

  // R2
  clk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_off == OFF_CLK) |=> (cs && sk == $past(wr_data[SK_BIT]) && di == $past(wr_data[DI_BIT])));

  // R4
  pass_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> ($past(wr_fire) && $past(wr_off) != OFF_CLK && $past(wr_off) != OFF_REL));

  // R4
  pins_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> ($stable(cs) && $stable(sk) && $stable(di)));

endmodule

// File: rtl/seep_rd_mask.sv
module seep_rd_mask #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              rd_single,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic              ee_do,
  output logic [DATA_W-1:0] rd_data
);

  logic gate;

  always_comb begin
    gate    = (rd_off == '0) && rd_single && !ee_do;
    rd_data = gate ? '0 : rd_raw;
  end

endmodule

// File: rtl/seep_cfg_port.sv
module seep_cfg_port #(
  parameter int OFF_W     = 8,
  parameter int DATA_W    = 8,
  parameter int IMG_BYTES = 128,
  localparam int AW       = $clog2(IMG_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  output logic              cfg_wr_ready,
  input  logic [OFF_W-1:0]  cfg_wr_off,
  input  logic [DATA_W-1:0] cfg_wr_data,
  output logic              pass_wr_valid,
  output logic [OFF_W-1:0]  pass_wr_off,
  output logic [DATA_W-1:0] pass_wr_data,
  input  logic [OFF_W-1:0]  cfg_rd_off,
  input  logic              cfg_rd_single,
  input  logic [DATA_W-1:0] cfg_rd_raw,
  output logic [DATA_W-1:0] cfg_rd_data,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do,
  output logic              img_valid,
  input  logic              img_ready,
  output logic [AW-1:0]     img_addr,
  output logic [7:0]        img_wdata,
  output logic              init_done
);

  logic wr_fire;

  always_comb begin
    cfg_wr_ready = init_done;
    wr_fire      = cfg_wr_valid && cfg_wr_ready;
  end

  seep_img_init #(.IMG_BYTES(IMG_BYTES)) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .img_valid (img_valid),
    .img_ready (img_ready),
    .img_addr  (img_addr),
    .img_wdata (img_wdata),
    .done      (init_done)
  );

  seep_pin_ctl #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_off     (cfg_wr_off),
    .wr_data    (cfg_wr_data),
    .pass_valid (pass_wr_valid),
    .pass_off   (pass_wr_off),
    .pass_data  (pass_wr_data),
    .cs         (ee_cs),
    .sk         (ee_sk),
    .di         (ee_di)
  );

  seep_rd_mask #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_rd (
    .rd_off    (cfg_rd_off),
    .rd_single (cfg_rd_single),
    .rd_raw    (cfg_rd_raw),
    .ee_do     (ee_do),
    .rd_data   (cfg_rd_data)
  );

  // R9
  no_write_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |=> (!pass_wr_valid && !ee_cs));

endmodule

// File: tb/tb_seep_cfg_port.sv
module tb_seep_cfg_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_valid = 1'b0;
  logic       cfg_wr_ready;
  logic [7:0] cfg_wr_off = '0;
  logic [7:0] cfg_wr_data = '0;
  logic       pass_wr_valid;
  logic [7:0] pass_wr_off;
  logic [7:0] pass_wr_data;
  logic [7:0] cfg_rd_off = '0;
  logic       cfg_rd_single = 1'b0;
  logic [7:0] cfg_rd_raw = '0;
  logic [7:0] cfg_rd_data;
  logic       ee_cs, ee_sk, ee_di;
  logic       ee_do = 1'b0;
  logic       img_valid;
  logic       img_ready = 1'b0;
  logic [6:0] img_addr;
  logic [7:0] img_wdata;
  logic       init_done;

  int checks = 0;
  int fails  = 0;
  logic [7:0] got_img [128];
  logic [7:0] exp_img [128];

  always #2.5 clk = ~clk;

  seep_cfg_port dut (.*);

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    cfg_wr_off   = off;
    cfg_wr_data  = data;
    cfg_wr_valid = 1'b1;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n_acc;
    int cyc;
    logic [15:0] s;
    logic [15:0] ck;
    logic order_ok;
    logic ready_low_seen;

    // expected image, computed from the requirement text
    for (int a = 0; a < 128; a++) exp_img[a] = 8'h00;
    for (int p = 0; p < 16; p++) exp_img[2*p] = 8'h57;
    exp_img[64] = 8'h07; exp_img[65] = 8'h0F; exp_img[67] = 8'h04; exp_img[68] = 8'h07;
    s = 16'h0;
    for (int a = 0; a < 126; a += 2) s = s + {exp_img[a+1], exp_img[a]};
    ck = 16'h1234 - s;
    exp_img[126] = ck[7:0];
    exp_img[127] = ck[15:8];

    // R1: reset state
    repeat (3) @(negedge clk);
    check(!ee_cs && !ee_sk && !ee_di, "R1 pins in reset", {ee_cs, ee_sk, ee_di}, 0);
    check(!pass_wr_valid && !init_done && !img_valid, "R1 flags in reset",
          {pass_wr_valid, init_done, img_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ee_cs && !pass_wr_valid && !init_done, "R1 after release",
          {ee_cs, pass_wr_valid, init_done}, 0);

    // R9: offer a clock write during init; it must not be taken
    cfg_wr_off = 8'h80; cfg_wr_data = 8'hC0; cfg_wr_valid = 1'b1;

    // R6/R7/R8: capture image with throttled ready
    n_acc = 0; cyc = 0; order_ok = 1'b1; ready_low_seen = 1'b0;
    while (n_acc < 128 && cyc < 2000) begin
      img_ready = (cyc % 3) != 1;
      #0.5;
      if (img_valid && !cfg_wr_ready) ready_low_seen = 1'b1;
      if (img_valid && img_ready) begin
        if (int'(img_addr) != n_acc) order_ok = 1'b0;
        got_img[img_addr] = img_wdata;
        n_acc++;
      end
      @(negedge clk);
      cyc++;
    end
    img_ready = 1'b0;
    cfg_wr_valid = 1'b0;
    check(order_ok && n_acc == 128, "R6 ascending order", n_acc, 128);
    check(init_done, "R6 done after last transfer", init_done, 1);
    check(ready_low_seen, "R9 ready low during init", ready_low_seen, 1);
    check(!ee_cs && !ee_sk && !ee_di && !pass_wr_valid, "R9 early write ignored",
          {ee_cs, ee_sk, ee_di, pass_wr_valid}, 0);
    for (int a = 0; a < 126; a++)
      check(got_img[a] === exp_img[a], $sformatf("R7 byte %0d", a), got_img[a], exp_img[a]);
    check(got_img[126] === exp_img[126], "R8 checksum low", got_img[126], exp_img[126]);
    check(got_img[127] === exp_img[127], "R8 checksum high", got_img[127], exp_img[127]);
    @(negedge clk);
    check(init_done && cfg_wr_ready && !img_valid, "R6 done sticky",
          {init_done, cfg_wr_ready, img_valid}, 3'b110);

    // R2/R3: sweep all data bytes through both pin offsets
    for (int d = 0; d < 256; d++) begin
      cfg_write(8'h80, d[7:0]);
      check(ee_cs && ee_sk == d[7] && ee_di == d[6] && !pass_wr_valid,
            "R2 clock write", {pass_wr_valid, ee_cs, ee_sk, ee_di}, {1'b0, 1'b1, d[7], d[6]});
      cfg_write(8'hC0, d[7:0]);
      check(!ee_cs && !ee_sk && !ee_di && !pass_wr_valid, "R3 release write",
            {pass_wr_valid, ee_cs, ee_sk, ee_di}, 0);
    end

    // R4: sweep all offsets, pins set to a known state first
    cfg_write(8'h80, 8'h80);
    for (int o = 0; o < 256; o++) begin
      logic [7:0] dv;
      dv = 8'(o * 37 + 5);
      if (o == 8'h80 || o == 8'hC0) continue;
      cfg_write(o[7:0], dv);
      check(pass_wr_valid && pass_wr_off == o[7:0] && pass_wr_data == dv,
            "R4 forwarded", {pass_wr_valid, pass_wr_off, pass_wr_data}, {1'b1, o[7:0], dv});
      check(ee_cs && ee_sk && !ee_di, "R4 pins untouched", {ee_cs, ee_sk, ee_di}, 3'b110);
      @(negedge clk);
      check(!pass_wr_valid, "R4 single-cycle strobe", pass_wr_valid, 0);
    end

    // R5: read mask over every offset, width and data-out level
    for (int o = 0; o < 256; o++) begin
      for (int w = 0; w < 2; w++) begin
        for (int q = 0; q < 2; q++) begin
          logic [7:0] rv, ev;
          rv = 8'(o ^ 8'hA5) | 8'h01;
          cfg_rd_off = o[7:0]; cfg_rd_single = w[0]; ee_do = q[0]; cfg_rd_raw = rv;
          #0.5;
          ev = (o == 0 && w == 1 && q == 0) ? 8'h00 : rv;
          check(cfg_rd_data == ev, "R5 read mask", cfg_rd_data, ev);
        end
      end
    end

    finish_run();
  end

endmodule